// File: doc/BRIEF.md
# Crosstalk-Avoiding Bus Codec

This block sits at both ends of a long on-chip parallel bus. It re-codes data so that no encoded word ever places a lone wire between two neighbours that both hold the opposite value. In other words, no three adjacent wires carry 010 or 101. A wire can then never switch against both of its neighbours at once, so the worst-case coupling load on any wire drops from four times the inter-wire capacitance to two times.

The transmit half takes a 16-bit word, splits it into four 4-bit groups and maps each group through a fixed 16-entry code to a 5-bit codeword. Between neighbouring codewords it places two boundary wires, which stops a forbidden pattern from forming across a group edge. The result is a 26-wire bus. The receive half takes a 26-wire word and decodes each 5-bit field back to its nibble, ignoring the boundary wires. It flags fields that are not valid codewords. It also flags words that break the adjacency rule. Each half has one register stage, and each carries a valid qualifier with one cycle of latency.

Top module: `xtc_codec`

## Requirements
- R1: Each nibble n maps to codeword c, with c written most significant bit first: 0→00000, 1→00001, 2→00110, 3→00011, 4→01100, 5→00111, 6→01110, 7→01111, 8→11111, 9→11110, 10→11001, 11→11100, 12→10011, 13→11000, 14→10001, 15→10000. Nibble g of the data is bits 4g+3..4g.
- R2: Codeword g occupies bus wires 7g..7g+4, with codeword bit j on wire 7g+j. For every g below the last group, wire 7g+5 repeats wire 7g+4 and wire 7g+6 repeats wire 7g+7.
- R3: Whenever tx_bus_valid is high, tx_bus has no three consecutive wires i, i+1, i+2 that read 010 or 101.
- R4: tx_bus_valid equals tx_valid delayed by one clock. tx_bus then shows the encoding of the tx_data sampled at that edge.
- R5: While rst is high at a clock edge, the block clears tx_bus_valid, rx_valid and all other outputs at that edge.
- R6: rx_valid equals rx_bus_valid delayed by one clock. rx_data then shows the decoded word, which for a word built per R1 and R2 is the original data.
- R7: The decoded data and rx_code_err do not depend on the boundary wires 7g+5 and 7g+6.
- R8: If any 5-bit field of a sampled rx_bus is not a codeword of R1, rx_code_err goes high with rx_valid, and that field's nibble in rx_data reads 0.
- R9: rx_pattern_err goes high with rx_valid exactly when the sampled rx_bus holds 010 or 101 on some three consecutive wires.
- R10: When the input valid is low, the matching output data and flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Qualifies tx_data |
| tx_data | input | 16 | Data word to encode |
| tx_bus_valid | output | 1 | Qualifies tx_bus |
| tx_bus | output | 26 | Encoded bus word |
| rx_bus_valid | input | 1 | Qualifies rx_bus |
| rx_bus | input | 26 | Received encoded word |
| rx_valid | output | 1 | Qualifies the receive results |
| rx_data | output | 16 | Decoded data word |
| rx_code_err | output | 1 | Some field is not a valid codeword |
| rx_pattern_err | output | 1 | Received word holds 010 or 101 |

## Verification
The properties assume that reset is held for at least one edge before valid traffic starts. They also assume that the valid inputs are clean 0 or 1 on every edge. The transmit-side legality and boundary properties hold for any tx_data, so the stimulus covers every nibble value in every group and also random words. The receive side is driven in three ways. It gets legal words, which show that the original data returns. It gets legal words with the boundary wires disturbed. And it gets fully arbitrary 26-bit words, which reach the code and pattern flags.

// File: rtl/xtc_pkg.sv
package xtc_pkg;

    localparam int NIB_W = 4;
    localparam int CW_W  = 5;
    localparam int PITCH = 7;
    localparam int NUM_CODES = 16;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CW_W-1:0]  cw_t;

    typedef struct packed {
        logic hit;
        nib_t nib;
    } dec_res_t;

    function automatic cw_t grp_encode(input nib_t n);
        cw_t c;
        case (n)
            4'h0: c = 5'b00000;
            4'h1: c = 5'b00001;
            4'h2: c = 5'b00110;
            4'h3: c = 5'b00011;
            4'h4: c = 5'b01100;
            4'h5: c = 5'b00111;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b11111;
            4'h9: c = 5'b11110;
            4'hA: c = 5'b11001;
            4'hB: c = 5'b11100;
            4'hC: c = 5'b10011;
            4'hD: c = 5'b11000;
            4'hE: c = 5'b10001;
            default: c = 5'b10000;
        endcase
        return c;
    endfunction

    function automatic dec_res_t grp_decode(input cw_t c);
        dec_res_t r;
        nib_t     kn;
        r = '0;
        for (int k = 0; k < NUM_CODES; k++) begin
            kn = nib_t'(k);
            if (grp_encode(kn) == c) begin
                r.hit = 1'b1;
                r.nib = kn;
            end
        end
        return r;
    endfunction

    function automatic logic tri_bad(input logic [2:0] t);
        return (t[0] ^ t[1]) & (t[1] ^ t[2]);
    endfunction

endpackage

// File: rtl/xtc_pattern_check.sv
module xtc_pattern_check #(
    parameter int W = 26
) (
    input  logic [W-1:0] word,
    output logic         bad
);
    import xtc_pkg::*;

    localparam int NWIN = W - 2;

    logic [NWIN-1:0] win_bad;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        assign win_bad[i] = tri_bad(word[i+2:i]);
    end

    assign bad = |win_bad;

endmodule

// File: rtl/xtc_encoder.sv
module xtc_encoder #(
    parameter int NG = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [NG*4-1:0]      in_data,
    output logic                 out_valid,
    output logic [NG*7-3:0]      out_bus
);
    import xtc_pkg::*;

    localparam int BW = NG * PITCH - 2;

    cw_t           cw [NG];
    logic [BW-1:0] bus_nxt;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign cw[g] = grp_encode(in_data[g*NIB_W +: NIB_W]);
        assign bus_nxt[g*PITCH +: CW_W] = cw[g];
        if (g < NG - 1) begin : g_bnd
            assign bus_nxt[g*PITCH + CW_W]     = cw[g][CW_W-1];
            assign bus_nxt[g*PITCH + CW_W + 1] = cw[g+1][0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bus   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bus <= bus_nxt;
            end
        end
    end

endmodule

// File: rtl/xtc_decoder.sv
module xtc_decoder #(
    parameter int NG = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [NG*7-3:0]      in_bus,
    output logic                 out_valid,
    output logic [NG*4-1:0]      out_data,
    output logic                 out_code_err,
    output logic                 out_pattern_err
);
    import xtc_pkg::*;

    localparam int BW = NG * PITCH - 2;
    localparam int DW = NG * NIB_W;

    dec_res_t      res [NG];
    logic [DW-1:0] data_nxt;
    logic [NG-1:0] miss;
    logic          pat_bad;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign res[g] = grp_decode(in_bus[g*PITCH +: CW_W]);
        assign data_nxt[g*NIB_W +: NIB_W] = res[g].hit ? res[g].nib : '0;
        assign miss[g] = ~res[g].hit;
    end

    xtc_pattern_check #(.W(BW)) chk_i (
        .word (in_bus),
        .bad  (pat_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid       <= 1'b0;
            out_data        <= '0;
            out_code_err    <= 1'b0;
            out_pattern_err <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data        <= data_nxt;
                out_code_err    <= |miss;
                out_pattern_err <= pat_bad;
            end
        end
    end

endmodule

// File: rtl/xtc_codec.sv
module xtc_codec #(
    parameter int NG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [NG*4-1:0]   tx_data,
    output logic              tx_bus_valid,
    output logic [NG*7-3:0]   tx_bus,
    input  logic              rx_bus_valid,
    input  logic [NG*7-3:0]   rx_bus,
    output logic              rx_valid,
    output logic [NG*4-1:0]   rx_data,
    output logic              rx_code_err,
    output logic              rx_pattern_err
);

    xtc_encoder #(.NG(NG)) enc_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .out_valid (tx_bus_valid),
        .out_bus   (tx_bus)
    );

    xtc_decoder #(.NG(NG)) dec_i (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (rx_bus_valid),
        .in_bus          (rx_bus),
        .out_valid       (rx_valid),
        .out_data        (rx_data),
        .out_code_err    (rx_code_err),
        .out_pattern_err (rx_pattern_err)
    );

endmodule

// File: rtl/xtc_codec_sva.sv
module xtc_codec_sva #(
    parameter int NG = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_valid,
    input logic [NG*4-1:0]   tx_data,
    input logic              tx_bus_valid,
    input logic [NG*7-3:0]   tx_bus,
    input logic              rx_bus_valid,
    input logic [NG*7-3:0]   rx_bus,
    input logic              rx_valid,
    input logic [NG*4-1:0]   rx_data,
    input logic              rx_code_err,
    input logic              rx_pattern_err
);
    localparam int BW = NG * 7 - 2;

    logic tx_has_bad;

    always_comb begin
        tx_has_bad = 1'b0;
        for (int i = 0; i + 2 < BW; i++) begin
            if (tx_bus[i +: 3] == 3'b010 || tx_bus[i +: 3] == 3'b101) begin
                tx_has_bad = 1'b1;
            end
        end
    end

    a_r3_tx_legal: assert property (@(posedge clk) disable iff (rst)
        tx_bus_valid |-> !tx_has_bad);

    a_r4_tx_valid_on: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_bus_valid);

    a_r4_tx_valid_off: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> !tx_bus_valid);

    a_r6_rx_valid_on: assert property (@(posedge clk) disable iff (rst)
        rx_bus_valid |=> rx_valid);

    a_r6_rx_valid_off: assert property (@(posedge clk) disable iff (rst)
        !rx_bus_valid |=> !rx_valid);

    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> (!tx_bus_valid && !rx_valid && !rx_code_err && !rx_pattern_err));

    a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> $stable(tx_bus));

    a_r10_rx_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_bus_valid |=> ($stable(rx_data) && $stable(rx_code_err) && $stable(rx_pattern_err)));

    for (genvar b = 0; b < NG - 1; b++) begin : g_bnd
        a_r2_boundary: assert property (@(posedge clk) disable iff (rst)
            tx_bus_valid |-> (tx_bus[7*b+5] == tx_bus[7*b+4] && tx_bus[7*b+6] == tx_bus[7*b+7]));
    end

endmodule

bind xtc_codec xtc_codec_sva #(.NG(NG)) sva_i (
    .clk            (clk),
    .rst            (rst),
    .tx_valid       (tx_valid),
    .tx_data        (tx_data),
    .tx_bus_valid   (tx_bus_valid),
    .tx_bus         (tx_bus),
    .rx_bus_valid   (rx_bus_valid),
    .rx_bus         (rx_bus),
    .rx_valid       (rx_valid),
    .rx_data        (rx_data),
    .rx_code_err    (rx_code_err),
    .rx_pattern_err (rx_pattern_err)
);

// File: tb/xtc_codec_tb_top.sv
`timescale 1ns/1ps
module xtc_codec_tb_top;

    localparam int NG = 4;
    localparam int DW = 16;
    localparam int BW = 26;

    logic          clk = 1'b0;
    logic          rst;
    logic          tx_valid;
    logic [DW-1:0] tx_data;
    logic          tx_bus_valid;
    logic [BW-1:0] tx_bus;
    logic          rx_bus_valid;
    logic [BW-1:0] rx_bus;
    logic          rx_valid;
    logic [DW-1:0] rx_data;
    logic          rx_code_err;
    logic          rx_pattern_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [4:0] tbl [16] = '{5'b00000, 5'b00001, 5'b00110, 5'b00011,
                             5'b01100, 5'b00111, 5'b01110, 5'b01111,
                             5'b11111, 5'b11110, 5'b11001, 5'b11100,
                             5'b10011, 5'b11000, 5'b10001, 5'b10000};

    logic          exp_txv, exp_rxv, exp_ce, exp_pe;
    logic [BW-1:0] exp_txb;
    logic [DW-1:0] exp_rxd;

    always #4 clk = ~clk;

    xtc_codec #(.NG(NG)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .tx_valid       (tx_valid),
        .tx_data        (tx_data),
        .tx_bus_valid   (tx_bus_valid),
        .tx_bus         (tx_bus),
        .rx_bus_valid   (rx_bus_valid),
        .rx_bus         (rx_bus),
        .rx_valid       (rx_valid),
        .rx_data        (rx_data),
        .rx_code_err    (rx_code_err),
        .rx_pattern_err (rx_pattern_err)
    );

    function automatic logic [BW-1:0] enc_word(input logic [DW-1:0] d);
        logic [BW-1:0] w = '0;
        logic [4:0] c;
        for (int g = 0; g < NG; g++) begin
            c = tbl[d[4*g +: 4]];
            for (int j = 0; j < 5; j++) w[7*g + j] = c[j];
        end
        for (int g = 0; g < NG - 1; g++) begin
            w[7*g + 5] = w[7*g + 4];
            w[7*g + 6] = w[7*g + 7];
        end
        return w;
    endfunction

    function automatic logic has_bad(input logic [BW-1:0] w);
        logic r = 1'b0;
        for (int i = 0; i + 2 < BW; i++)
            if (w[i +: 3] == 3'b010 || w[i +: 3] == 3'b101) r = 1'b1;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update(input logic r, input logic tv, input logic [DW-1:0] td,
                                input logic rv, input logic [BW-1:0] rb);
        logic found;
        if (r) begin
            exp_txv = 0; exp_txb = '0; exp_rxv = 0; exp_rxd = '0; exp_ce = 0; exp_pe = 0;
        end else begin
            exp_txv = tv;
            if (tv) exp_txb = enc_word(td);
            exp_rxv = rv;
            if (rv) begin
                exp_ce = 0;
                exp_rxd = '0;
                for (int g = 0; g < NG; g++) begin
                    found = 0;
                    for (int k = 0; k < 16; k++) begin
                        if (tbl[k] == rb[7*g +: 5]) begin
                            found = 1;
                            exp_rxd[4*g +: 4] = 4'(k);
                        end
                    end
                    if (!found) exp_ce = 1;
                end
                exp_pe = has_bad(rb);
            end
        end
    endtask

    task automatic tick(input logic r, input logic tv, input logic [DW-1:0] td,
                        input logic rv, input logic [BW-1:0] rb);
        rst = r; tx_valid = tv; tx_data = td; rx_bus_valid = rv; rx_bus = rb;
        @(posedge clk);
        model_update(r, tv, td, rv, rb);
        @(negedge clk);
        chk("R4 tx valid", 32'(tx_bus_valid), 32'(exp_txv));
        chk("R1 tx bus", 32'(tx_bus), 32'(exp_txb));
        chk("R6 rx valid", 32'(rx_valid), 32'(exp_rxv));
        chk("R6 rx data", 32'(rx_data), 32'(exp_rxd));
        chk("R8 code err", 32'(rx_code_err), 32'(exp_ce));
        chk("R9 pattern err", 32'(rx_pattern_err), 32'(exp_pe));
        if (tx_bus_valid) begin
            chk("R3 legal bus", 32'(has_bad(tx_bus)), 32'd0);
            for (int b = 0; b < NG - 1; b++) begin
                chk("R2 boundary lo", 32'(tx_bus[7*b+5]), 32'(tx_bus[7*b+4]));
                chk("R2 boundary hi", 32'(tx_bus[7*b+6]), 32'(tx_bus[7*b+7]));
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [BW-1:0] held;
        logic [BW-1:0] mask;
        exp_txv = 0; exp_txb = '0; exp_rxv = 0; exp_rxd = '0; exp_ce = 0; exp_pe = 0;
        @(negedge clk);

        // R5: reset state
        tick(1, 1, 16'hFFFF, 1, '1);
        tick(1, 0, '0, 0, '0);
        chk("R5 reset valids", 32'({tx_bus_valid, rx_valid}), 32'd0);

        // R1, R6: every nibble in every group, looped back
        for (int n = 0; n < 16; n++) begin
            d = {4'(n), 4'(n), 4'(n), 4'(n)};
            tick(0, 1, d, 1, enc_word(d));
        end
        for (int n = 0; n < 16; n++) begin
            d = {4'(n), 4'(15 - n), 4'((n + 5) % 16), 4'((n * 3) % 16)};
            tick(0, 1, d, 1, enc_word(d));
            tick(0, 1, ~d, 1, enc_word(d));
            chk("R6 round trip", 32'(rx_data), 32'(d));
        end

        // random traffic with random valid gaps
        for (int i = 0; i < 200; i++) begin
            d = 16'($urandom);
            tick(0, 1'($urandom), d, 1'($urandom), enc_word(16'($urandom)));
        end

        // R7: boundary wires disturbed, data unaffected
        for (int i = 0; i < 40; i++) begin
            d = 16'($urandom);
            mask = '0;
            for (int b = 0; b < NG - 1; b++) begin
                mask[7*b+5] = 1'($urandom);
                mask[7*b+6] = 1'($urandom);
            end
            tick(0, 0, '0, 1, enc_word(d) ^ mask);
            chk("R7 boundary ignored", 32'(rx_data), 32'(d));
            chk("R7 no code err", 32'(rx_code_err), 32'd0);
        end

        // R8: known bad codeword in group 2
        d = 16'h1234;
        mask = enc_word(d);
        mask[14 +: 5] = 5'b01010;
        tick(0, 0, '0, 1, mask);
        chk("R8 bad field", 32'(rx_code_err), 32'd1);
        chk("R8 zero nibble", 32'(rx_data), 32'h1034);
        chk("R9 pattern seen", 32'(rx_pattern_err), 32'd1);

        // R8, R9: arbitrary words
        for (int i = 0; i < 150; i++) begin
            tick(0, 1'($urandom), 16'($urandom), 1, 26'($urandom));
        end

        // R10: hold with valid low
        tick(0, 1, 16'hA5C3, 1, enc_word(16'h5A3C));
        held = tx_bus;
        d = rx_data;
        for (int i = 0; i < 5; i++) begin
            tick(0, 0, 16'($urandom), 0, 26'($urandom));
            chk("R10 tx hold", 32'(tx_bus), 32'(held));
            chk("R10 rx hold", 32'(rx_data), 32'(d));
        end

        // R5: reset mid stream
        tick(1, 1, 16'h7777, 1, enc_word(16'h7777));
        chk("R5 mid reset", 32'({tx_bus_valid, rx_valid, rx_code_err, rx_pattern_err}), 32'd0);
        tick(0, 1, 16'h0F0F, 1, enc_word(16'h0F0F));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule